// File: doc/BRIEF.md
# Host Bridge Control Register File

This block holds the control and configuration words of a host-to-peripheral bridge. It is a bank of 32-bit words on a simple memory-mapped bus. A word is selected by the byte address shifted right by two. Only whole-word, word-aligned accesses are honoured. Most words are plain storage that loads a defined default at reset.

A few words behave differently:
- The interrupt-enable word cannot be written directly. Bits are turned on through a set alias and turned off through a clear alias.
- The enable word and the interrupt status word are read-only.
- One bit of the general configuration word acts as a soft-reset trigger. A 0-to-1 change of that bit, made by a bus write, produces a one-cycle reset-request pulse for the system.

Reads return data one clock after the access is accepted. The output holds its value until the next read.

Top module: `hbctl_regbank`

## Requirements
- R1: After reset, the word defaults (byte offset = value) are:
  - 0x00 = 0x00000C40
  - 0x04 = 0x00001384
  - 0x08 = 0x2BFF8010
  - 0x0C = 0x255E0091
  - 0x10 = 0x00006140
  - 0x1C = 0x000001FF
  - 0x20 = 0x000001FF
  - 0x68 = 0x00000008
  - 0x6C = 0x10000000
  
  Every other word of the bank resets to zero, and rd_data and reset_req are low.
- R2: An access is accepted when bus_sel is high, bus_size is 2'b10 and bus_addr[1:0] is 0. The word index is bus_addr >> 2. An accepted write to a plain word (offsets 0x00 to 0x6C other than 0x38 and 0x3C) stores bus_wdata. An accepted read presents that word on rd_data after the next rising clock edge.
- R3: An access with bus_size other than 2'b10, or with bus_addr[1:0] not zero, changes no word. Such a read drives rd_data to zero.
- R4: An accepted write to offset 0x30 stores the value at 0x30 and ORs it into the enable word at 0x38.
- R5: An accepted write to offset 0x34 stores the value at 0x34 and clears, in the enable word, every bit that is 1 in the written value.
- R6: Writes to 0x38 and 0x3C are ignored. 0x38 reads the enable word, and 0x3C always reads zero.
- R7: An accepted write to offset 0x04 whose data bit 2 is 1, while the stored bit 2 is 0, stores the value. It also drives reset_req high for exactly the one cycle after the write edge.
- R8: Any other write to offset 0x04 (stored bit 2 already 1, or new bit 2 equal to 0) stores the value and leaves reset_req low.
- R9: Accepted writes to word offsets from 0x70 upward are ignored, and reads of them return zero.
- R10: rd_data changes only on an accepted read or an R3 read. It holds through idle and write cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size as log2 of bytes; only 2'b10 is accepted |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Registered read data |
| reset_req | output | 1 | One-cycle soft reset request |

## Verification
The bench uses the default build: 32-bit data, an 8-bit byte address and 28 words. The 8-bit address gives 64 word slots, so one sweep touches every word of the bank and 36 slots beyond it. This brings the out-of-bank rule, the alias side effects and the reset-request condition into reach for every index in one pass.

The sweep runs twice, once with an arithmetic data pattern and once with its complement. In the second pass, bit 2 of the configuration word rises, so the request pulse appears in the second pass and not in the first. Directed sequences then cover rejected size and alignment codes, the repeated-one case of the trigger bit, and the hold of read data.

// File: rtl/hbctl_pkg.sv
package hbctl_pkg;

   localparam int HB_MIN_WORDS  = 28;
   localparam int HB_CFG_IDX    = 1;   // general configuration word
   localparam int HB_SRST_BIT   = 2;   // soft reset trigger bit
   localparam int HB_EN_SET_IDX = 12;  // set alias
   localparam int HB_EN_CLR_IDX = 13;  // clear alias
   localparam int HB_EN_IDX     = 14;  // enable word, read-only
   localparam int HB_STAT_IDX   = 15;  // status word, read-only
   localparam logic [1:0] HB_SIZE_WORD = 2'b10;

   typedef enum logic [1:0] {
      WK_PLAIN,
      WK_ENABLE,
      WK_STATUS
   } word_kind_e;

   function automatic word_kind_e word_kind(int idx);
      if (idx == HB_EN_IDX)   return WK_ENABLE;
      if (idx == HB_STAT_IDX) return WK_STATUS;
      return WK_PLAIN;
   endfunction

   function automatic logic [31:0] word_default(int idx);
      case (idx)
         0:       return 32'h0000_0C40;
         1:       return 32'h0000_1384;
         2:       return 32'h2BFF_8010;
         3:       return 32'h255E_0091;
         4:       return 32'h0000_6140;
         7:       return 32'h0000_01FF;
         8:       return 32'h0000_01FF;
         26:      return 32'h0000_0008;
         27:      return 32'h1000_0000;
         default: return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/hbctl_decode.sv
module hbctl_decode #(
   parameter int ADDR_W    = 8,
   parameter int NUM_WORDS = 28,
   localparam int IDX_W    = ADDR_W - 2
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_size,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [NUM_WORDS-1:0] wr_hit,
   output logic              rd_take,
   output logic              rd_good,
   output logic [IDX_W-1:0]  rd_idx
);
   logic             legal;
   logic [IDX_W-1:0] idx;

   assign idx     = bus_addr[ADDR_W-1:2];
   assign legal   = bus_sel && (bus_size == hbctl_pkg::HB_SIZE_WORD) && (bus_addr[1:0] == 2'b00);
   assign rd_take = bus_sel && !bus_wr;
   assign rd_good = legal;
   assign rd_idx  = idx;

   for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_hit
      assign wr_hit[gi] = legal && bus_wr && (idx == IDX_W'(gi));
   end
endmodule

// File: rtl/hbctl_word.sv
module hbctl_word #(
   parameter int DATA_W = 32,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/hbctl_inten.sv
module hbctl_inten #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] en_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '0;
      else if (set_we) en_q <= en_q | wdata;
      else if (clr_we) en_q <= en_q & ~wdata;
   end
endmodule

// File: rtl/hbctl_srst.sv
module hbctl_srst (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_we,
   input  logic old_bit,
   input  logic new_bit,
   output logic req_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= cfg_we && !old_bit && new_bit;
   end
endmodule

// File: rtl/hbctl_regbank.sv
module hbctl_regbank #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int NUM_WORDS = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_size,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              reset_req
);
   import hbctl_pkg::*;

   localparam int IDX_W = ADDR_W - 2;

   if (DATA_W < 32) begin : g_bad_data_w
      $error("hbctl_regbank: DATA_W must hold the 32-bit defaults");
   end
   if (NUM_WORDS < HB_MIN_WORDS) begin : g_bad_words
      $error("hbctl_regbank: NUM_WORDS too small for the defined map");
   end
   if ((2 ** IDX_W) < NUM_WORDS) begin : g_bad_addr_w
      $error("hbctl_regbank: ADDR_W cannot reach every word");
   end

   logic [NUM_WORDS-1:0] wr_hit;
   logic                 rd_take;
   logic                 rd_good;
   logic [IDX_W-1:0]     rd_idx;
   logic [DATA_W-1:0]    word_q [NUM_WORDS];
   logic [DATA_W-1:0]    en_q;
   logic [DATA_W-1:0]    rd_mux;
   logic [DATA_W-1:0]    rd_q;

   hbctl_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_WORDS(NUM_WORDS)
   ) u_decode (
      .bus_sel (bus_sel),
      .bus_wr  (bus_wr),
      .bus_size(bus_size),
      .bus_addr(bus_addr),
      .wr_hit  (wr_hit),
      .rd_take (rd_take),
      .rd_good (rd_good),
      .rd_idx  (rd_idx)
   );

   hbctl_inten #(.DATA_W(DATA_W)) u_inten (
      .clk   (clk),
      .rst_n (rst_n),
      .set_we(wr_hit[HB_EN_SET_IDX]),
      .clr_we(wr_hit[HB_EN_CLR_IDX]),
      .wdata (bus_wdata),
      .en_q  (en_q)
   );

   for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
      if (word_kind(gi) == WK_ENABLE) begin : g_en
         assign word_q[gi] = en_q;
      end else if (word_kind(gi) == WK_STATUS) begin : g_stat
         assign word_q[gi] = '0;
      end else begin : g_plain
         hbctl_word #(
            .DATA_W (DATA_W),
            .RST_VAL(DATA_W'(word_default(gi)))
         ) u_word (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (wr_hit[gi]),
            .wdata(bus_wdata),
            .q    (word_q[gi])
         );
      end
   end

   hbctl_srst u_srst (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_we (wr_hit[HB_CFG_IDX]),
      .old_bit(word_q[HB_CFG_IDX][HB_SRST_BIT]),
      .new_bit(bus_wdata[HB_SRST_BIT]),
      .req_q  (reset_req)
   );

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (rd_idx == IDX_W'(i)) rd_mux = word_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_q <= '0;
      else if (rd_take) rd_q <= rd_good ? rd_mux : '0;
   end

   assign rd_data = rd_q;
endmodule

// File: rtl/hbctl_regbank_chk.sv
module hbctl_regbank_chk #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int NUM_WORDS = 28
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [1:0]        bus_size,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] rd_data,
   input logic              reset_req,
   input logic [DATA_W-1:0] en_q
);
   localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(hbctl_pkg::HB_CFG_IDX * 4);
   localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(hbctl_pkg::HB_EN_SET_IDX * 4);
   localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(hbctl_pkg::HB_EN_CLR_IDX * 4);

   logic legal, wv, rv;
   assign legal = bus_sel && bus_size == hbctl_pkg::HB_SIZE_WORD && bus_addr[1:0] == 2'b00;
   assign wv    = legal && bus_wr;
   assign rv    = legal && !bus_wr;

   a_r7_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> $past(wv && bus_addr == CFG_A && bus_wdata[hbctl_pkg::HB_SRST_BIT]));

   a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req);

   a_r4_set_or: assert property (@(posedge clk) disable iff (!rst_n)
      (wv && bus_addr == SET_A) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

   a_r5_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (wv && bus_addr == CLR_A) |=> ((en_q & $past(bus_wdata)) == '0));

   a_r6_en_alias_only: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(en_q) |-> $past(wv && (bus_addr == SET_A || bus_addr == CLR_A)));

   a_r9_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rv && int'(bus_addr) >= NUM_WORDS * 4) |=> (rd_data == '0));

   a_r3_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && !legal) |=> (rd_data == '0));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_wr) |=> $stable(rd_data));
endmodule

bind hbctl_regbank hbctl_regbank_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .NUM_WORDS(NUM_WORDS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_size (bus_size),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .rd_data  (rd_data),
   .reset_req(reset_req),
   .en_q     (en_q)
);

// File: tb/hbctl_regbank_tb.sv
module hbctl_regbank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_size = 2'b10;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rd_data;
   logic        reset_req;

   int checks = 0;
   int errors = 0;

   logic [31:0] m [64];
   logic [31:0] m_en;

   always #5 clk = ~clk;

   hbctl_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .rd_data(rd_data), .reset_req(reset_req)
   );

   function automatic logic [31:0] dflt(int idx);
      case (idx)
         0: return 32'hC40;       1: return 32'h1384;
         2: return 32'h2BFF8010;  3: return 32'h255E0091;
         4: return 32'h6140;      7: return 32'h1FF;
         8: return 32'h1FF;       26: return 32'h8;
         27: return 32'h10000000; default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] expect_rd(int idx);
      if (idx >= 28) return 32'h0;
      if (idx == 14) return m_en;
      if (idx == 15) return 32'h0;
      return m[idx];
   endfunction

   function automatic string tag_of(int idx);
      if (idx >= 28) return "R9";
      if (idx == 12) return "R4";
      if (idx == 13) return "R5";
      if (idx == 14 || idx == 15) return "R6";
      return "R2";
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(int idx, logic [31:0] d);
      logic pulse;
      pulse = (idx == 1) && !m[1][2] && d[2];
      if (idx < 28 && idx != 14 && idx != 15) m[idx] = d;
      if (idx == 12) m_en = m_en | d;
      if (idx == 13) m_en = m_en & ~d;
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_size = 2'b10;
      bus_addr = 8'(idx * 4); bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0;
      check(pulse ? "R7" : "R8", {31'b0, reset_req}, {31'b0, pulse});
   endtask

   task automatic do_read(logic [7:0] a, logic [1:0] sz, logic [31:0] exp, string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_size = sz; bus_addr = a;
      @(posedge clk); #1;
      bus_sel = 1'b0;
      check(tag, rd_data, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] held;
      for (int i = 0; i < 64; i++) m[i] = dflt(i);
      m_en = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 rd_data", rd_data, 32'h0);
      check("R1 reset_req", {31'b0, reset_req}, 32'h0);
      @(negedge clk) rst_n = 1'b1;

      // R1: defaults over every slot
      for (int i = 0; i < 64; i++) do_read(8'(i * 4), 2'b10, dflt(i), "R1");

      // two write sweeps, pattern then complement
      for (int p = 0; p < 2; p++) begin
         for (int i = 0; i < 64; i++) begin
            logic [31:0] d;
            d = 32'(i + 1) * 32'h9E3779B9;
            if (p == 1) d = ~d;
            do_write(i, d);
         end
         for (int i = 0; i < 64; i++) do_read(8'(i * 4), 2'b10, expect_rd(i), tag_of(i));
      end

      // R4 / R5 directed
      do_write(13, 32'hFFFF_FFFF);
      do_read(8'h38, 2'b10, 32'h0, "R5");
      do_write(12, 32'h0000_F0F0);
      do_read(8'h38, 2'b10, 32'h0000_F0F0, "R4");
      do_read(8'h30, 2'b10, 32'h0000_F0F0, "R4");
      do_write(12, 32'h0F00_0001);
      do_read(8'h38, 2'b10, 32'h0F00_F0F1, "R4");
      do_write(13, 32'h0000_00F1);
      do_read(8'h38, 2'b10, 32'h0F00_F000, "R5");
      do_read(8'h34, 2'b10, 32'h0000_00F1, "R5");
      do_write(14, 32'hDEAD_BEEF);
      do_write(15, 32'hDEAD_BEEF);
      do_read(8'h38, 2'b10, 32'h0F00_F000, "R6");
      do_read(8'h3C, 2'b10, 32'h0, "R6");

      // R7 / R8 soft reset trigger
      do_write(1, 32'h0000_1380);
      do_write(1, 32'h0000_1384);
      @(posedge clk); #1;
      check("R7 drop", {31'b0, reset_req}, 32'h0);
      do_write(1, 32'h0000_0004);
      do_read(8'h04, 2'b10, 32'h0000_0004, "R8");

      // R3 rejected size and alignment
      do_write(16, 32'h1234_5678);
      for (int s = 0; s < 4; s++) begin
         if (s != 2) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'b1; bus_size = 2'(s);
            bus_addr = 8'h40; bus_wdata = 32'hFFFF_0000;
            @(posedge clk); #1;
            bus_sel = 1'b0;
            do_read(8'h40, 2'(s), 32'h0, "R3");
         end
      end
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_size = 2'b10;
      bus_addr = 8'h42; bus_wdata = 32'hAAAA_AAAA;
      @(posedge clk); #1;
      bus_sel = 1'b0;
      do_read(8'h40, 2'b10, 32'h1234_5678, "R3");
      do_read(8'h41, 2'b10, 32'h0, "R3");

      // R10 hold
      do_read(8'h40, 2'b10, 32'h1234_5678, "R10");
      held = rd_data;
      repeat (3) @(posedge clk);
      #1;
      check("R10 idle", rd_data, held);
      do_write(17, 32'h5555_AAAA);
      check("R10 write", rd_data, held);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule